// File: doc/BRIEF.md
# Dual-Protocol Two-Wire Control Register Slave

This block is a slave on a two-wire serial bus. It holds three 8-bit control registers whose 24 bits drive a parallel word that switches individual clock outputs on or off. The bus master reaches the registers in one of two framings, and the device address it sends picks the framing for that transaction. One address gives pointer-based register access: the first byte sets a register index, and later bytes write or read from that index onward. The other address gives block access, which always starts at register 0 and carries a command byte and a byte count.

SCL and SDA are sampled in a fast system clock domain through synchronizers. Edges found there mark bit timing and the bus START and STOP conditions. The block never drives SDA high. It drives an open-drain enable, and a 1 on that enable pulls the line low. A register takes its new value as soon as the slave acknowledges the data byte, without waiting for STOP. After the last register the index wraps to register 0, so a long burst overwrites the registers again in order.

Top module: `twin_proto_regslave`

## Requirements
- R1: Reset sets all 24 bits of `ctrl_word` to 1 and keeps `sda_oe` at 0.
- R2: A transaction begins only on a START, which is SDA falling while SCL is high. A STOP, which is SDA rising while SCL is high, returns the slave to idle. Bytes clocked without a preceding START are not acknowledged.
- R3: Address bytes are sent MSB first, as 7 address bits and then the R/W bit. Address 1101001 selects block framing. Address 1011x00, where bit 2 is ignored, selects pointer framing. The slave acknowledges either address by driving SDA low in the ninth clock. It does not acknowledge any other address, and it ignores the bus until the next START.
- R4: In pointer framing with R/W=0, the first byte after the address loads the register index. A value of 3 or more loads index 0. Each later data byte is written to the indexed register, and the index then advances by one.
- R5: The register index advances from 2 to 0, for writes and for reads alike.
- R6: A register and its bits in `ctrl_word` change when the slave acknowledges the data byte, before any STOP. A STOP or repeated START in the middle of a data byte discards the partial byte and leaves every register unchanged.
- R7: In pointer framing, a write phase that sets the index, then a repeated START, then the address with R/W=1 makes the slave return register bytes MSB first. The first byte comes from the index and the index advances after each byte. A master NACK ends the read and the slave releases SDA.
- R8: In block framing with R/W=0, a command byte of 0x00 is acknowledged. A nonzero command byte is not acknowledged and ends the transaction with no register change. The next byte is a byte count, which is acknowledged and ignored. Data bytes then fill registers from index 0.
- R9: In block framing, a read after the address with R/W=1 first returns a count byte equal to 3. It then returns registers 0, 1, 2, 0, and so on until the master NACKs.
- R10: Register n drives `ctrl_word[8n+7:8n]`.
- R11: The slave never pulls SDA low while idle. It changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| ctrl_word | output | 24 | Clock-enable bits, register n in bits 8n+7:8n |

## Verification
Two things can happen on the same system clock edge: the write of a data byte into the last register and the wrap of the index back to 0. The stimulus provokes this with a two-byte pointer-framing write that starts at index 2. The check then looks at where each byte lands: the first must appear in bits 23:16 and the second in bits 7:0. A second collision is a START or STOP arriving while a byte is partly shifted in. The stimulus cuts a data byte short with each kind of condition, and the check confirms that `ctrl_word` is unchanged afterward.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    LK_IDLE,
    LK_RECV,
    LK_ACK,
    LK_SEND,
    LK_MACK
  } link_st_e;

  typedef enum logic [1:0] {
    RK_ADDR,
    RK_INDEX,
    RK_COUNT,
    RK_DATA
  } rx_kind_e;

  typedef enum logic {
    PR_PTR,
    PR_BLK
  } proto_e;
endpackage

// File: rtl/tps_line_sync.sv
module tps_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  // data edges while the clock stays high are bus conditions
  assign bus_start = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/tps_reg_bank.sv
module tps_reg_bank #(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned W        = 8,
  parameter int unsigned IDX_W    = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [W-1:0]          wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [W-1:0]          rd_data,
  output logic [NUM_REGS*W-1:0] word
);
  localparam logic [IDX_W:0] COUNT = (IDX_W+1)'(NUM_REGS);

  logic [W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = ({1'b0, rd_idx} < COUNT) ? mem[rd_idx] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    assign word[g*W +: W] = mem[g];
  end
endmodule

// File: rtl/tps_link_ctrl.sv
module tps_link_ctrl
  import tps_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 3,
  parameter int unsigned IDX_W       = 2,
  parameter logic [6:0]  BLK_ADDR    = 7'b1101001,
  parameter logic [6:0]  PTR_ADDR    = 7'b1011000,
  parameter logic [6:0]  PTR_DC_MASK = 7'b0000100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_drive,
  output logic              link_idle
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_REGS - 1);
  localparam logic [BYTE_W-1:0] BLOCK_LEN = BYTE_W'(NUM_REGS);

  link_st_e          st;
  rx_kind_e          kind;
  proto_e            proto;
  logic              rw;
  logic [BYTE_W-1:0] shreg;
  logic [3:0]        bitcnt;
  logic [IDX_W-1:0]  ptr;
  logic              count_pend;
  logic              host_ack;
  logic              blk_hit;
  logic              ptr_hit;
  logic [BYTE_W-1:0] tx_byte;
  logic              send_count;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign blk_hit    = (shreg[BYTE_W-1:1] == BLK_ADDR);
  assign ptr_hit    = (((shreg[BYTE_W-1:1] ^ PTR_ADDR) & ~PTR_DC_MASK) == 7'd0);
  assign send_count = (proto == PR_BLK) && count_pend;
  assign tx_byte    = send_count ? BLOCK_LEN : rd_data;
  assign rd_idx     = ptr;
  assign link_idle  = (st == LK_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= LK_IDLE;
      kind       <= RK_ADDR;
      proto      <= PR_PTR;
      rw         <= 1'b0;
      shreg      <= '0;
      bitcnt     <= '0;
      ptr        <= '0;
      count_pend <= 1'b0;
      host_ack   <= 1'b0;
      sda_drive  <= 1'b0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (bus_start) begin
        st        <= LK_RECV;
        kind      <= RK_ADDR;
        bitcnt    <= '0;
        sda_drive <= 1'b0;
      end else if (bus_stop) begin
        st        <= LK_IDLE;
        sda_drive <= 1'b0;
      end else begin
        case (st)
          LK_RECV: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              case (kind)
                RK_ADDR: begin
                  if (blk_hit || ptr_hit) begin
                    proto      <= blk_hit ? PR_BLK : PR_PTR;
                    rw         <= shreg[0];
                    count_pend <= 1'b1;
                    kind       <= RK_INDEX;
                    if (blk_hit) ptr <= '0;
                    st         <= LK_ACK;
                    sda_drive  <= 1'b1;
                  end else begin
                    st <= LK_IDLE;
                  end
                end
                RK_INDEX: begin
                  if (proto == PR_PTR) begin
                    ptr       <= (shreg < BLOCK_LEN) ? shreg[IDX_W-1:0] : '0;
                    kind      <= RK_DATA;
                    st        <= LK_ACK;
                    sda_drive <= 1'b1;
                  end else if (shreg == '0) begin
                    ptr       <= '0;
                    kind      <= RK_COUNT;
                    st        <= LK_ACK;
                    sda_drive <= 1'b1;
                  end else begin
                    st <= LK_IDLE;
                  end
                end
                RK_COUNT: begin
                  kind      <= RK_DATA;
                  st        <= LK_ACK;
                  sda_drive <= 1'b1;
                end
                default: begin
                  wr_en     <= 1'b1;
                  wr_idx    <= ptr;
                  wr_data   <= shreg;
                  ptr       <= step(ptr);
                  st        <= LK_ACK;
                  sda_drive <= 1'b1;
                end
              endcase
            end
          end
          LK_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                shreg     <= tx_byte;
                sda_drive <= ~tx_byte[BYTE_W-1];
                st        <= LK_SEND;
                if (send_count) count_pend <= 1'b0;
                else            ptr        <= step(ptr);
              end else begin
                sda_drive <= 1'b0;
                st        <= LK_RECV;
              end
            end
          end
          LK_SEND: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_drive <= 1'b0;
                st        <= LK_MACK;
              end else begin
                shreg     <= {shreg[BYTE_W-2:0], 1'b0};
                sda_drive <= ~shreg[BYTE_W-2];
                bitcnt    <= bitcnt + 4'd1;
              end
            end
          end
          LK_MACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (host_ack) begin
                bitcnt    <= '0;
                shreg     <= tx_byte;
                sda_drive <= ~tx_byte[BYTE_W-1];
                st        <= LK_SEND;
                if (send_count) count_pend <= 1'b0;
                else            ptr        <= step(ptr);
              end else begin
                st <= LK_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twin_proto_regslave.sv
module twin_proto_regslave #(
  parameter int unsigned NUM_REGS    = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  BLK_ADDR    = 7'b1101001,
  parameter logic [6:0]  PTR_ADDR    = 7'b1011000,
  parameter logic [6:0]  PTR_DC_MASK = 7'b0000100
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] ctrl_word
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int unsigned W     = tps_pkg::BYTE_W;

  logic             sda_lvl;
  logic             scl_rise;
  logic             scl_fall;
  logic             bus_start;
  logic             bus_stop;
  logic [W-1:0]     rd_data;
  logic [IDX_W-1:0] rd_idx;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [W-1:0]     wr_data;
  logic             link_idle;

  tps_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_raw  (scl_i),
    .sda_raw  (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  tps_link_ctrl #(
    .NUM_REGS   (NUM_REGS),
    .IDX_W      (IDX_W),
    .BLK_ADDR   (BLK_ADDR),
    .PTR_ADDR   (PTR_ADDR),
    .PTR_DC_MASK(PTR_DC_MASK)
  ) u_link (
    .clk      (clk),
    .rst      (rst),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sda_drive(sda_oe),
    .link_idle(link_idle)
  );

  tps_reg_bank #(.NUM_REGS(NUM_REGS), .W(W), .IDX_W(IDX_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .rd_idx (rd_idx),
    .rd_data(rd_data),
    .word   (ctrl_word)
  );
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned IDX_W    = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_oe,
  input logic [NUM_REGS*8-1:0] ctrl_word,
  input logic                  link_idle,
  input logic                  wr_en,
  input logic [IDX_W-1:0]      wr_idx,
  input logic [IDX_W-1:0]      rd_idx
);
  localparam logic [IDX_W:0] COUNT = (IDX_W+1)'(NUM_REGS);

  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      AST_RESET_ALL_ON: assert (ctrl_word == '1 && !sda_oe); // R1
    end
  end

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    link_idle |-> !sda_oe); // R11

  AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_i); // R11

  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(ctrl_word)); // R6

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ({1'b0, wr_idx} < COUNT)); // R4

  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    {1'b0, rd_idx} < COUNT); // R5
endmodule

bind twin_proto_regslave tps_checker #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_tps_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .ctrl_word(ctrl_word),
  .link_idle(link_idle),
  .wr_en    (wr_en),
  .wr_idx   (wr_idx),
  .rd_idx   (rd_idx)
);

// File: tb/tb_twin_proto_regslave.sv
module tb_twin_proto_regslave;
  localparam int Q = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [23:0] ctrl_word;
  logic        sda_line;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;
  logic [7:0]  model [3];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twin_proto_regslave dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .ctrl_word(ctrl_word)
  );

  // mode(2) idx/count(8) d0(8) d1(8); mode 0/1 pointer framing, 2 block framing
  localparam logic [25:0] VEC [6] = '{
    {2'd0, 8'h00, 8'h12, 8'h34},
    {2'd1, 8'h02, 8'h56, 8'h78},
    {2'd2, 8'h07, 8'h9A, 8'hBC},
    {2'd0, 8'h01, 8'h00, 8'hFF},
    {2'd0, 8'h05, 8'hA5, 8'h5A},
    {2'd2, 8'h02, 8'h0F, 8'hF0}
  };

  task automatic pause(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; pause(Q); scl_m = 1'b1; pause(Q);
    sda_m = 1'b0; pause(Q); scl_m = 1'b0; pause(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; pause(Q); scl_m = 1'b1; pause(Q); sda_m = 1'b1; pause(Q);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_m = b; pause(Q); scl_m = 1'b1; pause(Q);
    seen = sda_line; pause(Q); scl_m = 1'b0; pause(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  function automatic logic [23:0] mword();
    return {model[2], model[1], model[0]};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic       ak;
    logic [7:0] rb;
    for (int i = 0; i < 3; i++) model[i] = 8'hFF;
    pause(10);
    rst = 1'b0;
    pause(4);
    check("R1 reset word", {8'h0, ctrl_word}, 32'h00FFFFFF);
    check("R1 reset sda", {31'h0, sda_oe}, 32'h0);

    // table of writes; R4 R5 R8 R10
    for (int v = 0; v < 6; v++) begin
      logic [1:0] md;
      logic [7:0] ix, a0, a1, ad;
      logic       ok;
      int         p;
      {md, ix, a0, a1} = VEC[v];
      ad = (md == 2'd0) ? 8'hB0 : (md == 2'd1) ? 8'hB8 : 8'hD2;
      ok = 1'b1;
      bus_start();
      put_byte(ad, ak); ok &= ak;
      if (md == 2'd2) begin put_byte(8'h00, ak); ok &= ak; end
      put_byte(ix, ak); ok &= ak;
      put_byte(a0, ak); ok &= ak;
      put_byte(a1, ak); ok &= ak;
      bus_stop();
      p = (md == 2'd2) ? 0 : ((ix < 8'd3) ? int'(ix) : 0);
      model[p] = a0;
      p = (p + 1) % 3;
      model[p] = a1;
      check("R3 all bytes acked", {31'h0, ok}, 32'h1);
      check("R10 word after write", {8'h0, ctrl_word}, {8'h0, mword()});
    end

    // R3: foreign addresses get no ACK and are ignored
    bus_start();
    put_byte(8'hA0, ak);
    check("R3 foreign addr nack", {31'h0, ak}, 32'h0);
    check("R11 idle released", {31'h0, sda_oe}, 32'h0);
    put_byte(8'h00, ak);
    check("R3 ignored after miss", {31'h0, ak}, 32'h0);
    bus_stop();
    bus_start();
    put_byte(8'hB2, ak);
    check("R3 addr bit0 differs nack", {31'h0, ak}, 32'h0);
    bus_stop();
    check("R3 word untouched", {8'h0, ctrl_word}, {8'h0, mword()});

    // R2: address clocked without START
    put_byte(8'hB0, ak);
    check("R2 no start no ack", {31'h0, ak}, 32'h0);
    bus_stop();

    // R7: pointer-framing read from index 1, wraps
    bus_start();
    put_byte(8'hB0, ak);
    put_byte(8'h01, ak);
    bus_start();
    put_byte(8'hB1, ak);
    check("R7 read addr ack", {31'h0, ak}, 32'h1);
    get_byte(1'b1, rb); check("R7 byte idx1", {24'h0, rb}, {24'h0, model[1]});
    get_byte(1'b1, rb); check("R7 byte idx2", {24'h0, rb}, {24'h0, model[2]});
    get_byte(1'b0, rb); check("R5 read wrap idx0", {24'h0, rb}, {24'h0, model[0]});
    check("R7 released after nack", {31'h0, sda_oe}, 32'h0);
    bus_stop();

    // R9: block read with count byte
    bus_start();
    put_byte(8'hD2, ak);
    put_byte(8'h00, ak);
    bus_start();
    put_byte(8'hD3, ak);
    get_byte(1'b1, rb); check("R9 count byte", {24'h0, rb}, 32'd3);
    get_byte(1'b1, rb); check("R9 reg0", {24'h0, rb}, {24'h0, model[0]});
    get_byte(1'b1, rb); check("R9 reg1", {24'h0, rb}, {24'h0, model[1]});
    get_byte(1'b1, rb); check("R9 reg2", {24'h0, rb}, {24'h0, model[2]});
    get_byte(1'b0, rb); check("R9 wrap reg0", {24'h0, rb}, {24'h0, model[0]});
    bus_stop();

    // R8: nonzero command refused
    bus_start();
    put_byte(8'hD2, ak);
    put_byte(8'h01, ak);
    check("R8 nonzero cmd nack", {31'h0, ak}, 32'h0);
    put_byte(8'h00, ak);
    put_byte(8'h11, ak);
    bus_stop();
    check("R8 word untouched", {8'h0, ctrl_word}, {8'h0, mword()});

    // R6: commit before STOP
    bus_start();
    put_byte(8'hB0, ak);
    put_byte(8'h02, ak);
    put_byte(8'h3C, ak);
    model[2] = 8'h3C;
    check("R6 commit before stop", {8'h0, ctrl_word}, {8'h0, mword()});
    bus_stop();

    // R6: partial byte cut by STOP
    bus_start();
    put_byte(8'hB0, ak);
    put_byte(8'h00, ak);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, ak);
    bus_stop();
    check("R6 stop discards partial", {8'h0, ctrl_word}, {8'h0, mword()});

    // R6: partial byte cut by repeated START
    bus_start();
    put_byte(8'hB0, ak);
    put_byte(8'h01, ak);
    for (int i = 0; i < 5; i++) clk_bit(1'b0, ak);
    bus_start();
    put_byte(8'hB8, ak);
    check("R6 restart readdressed", {31'h0, ak}, 32'h1);
    put_byte(8'h02, ak);
    bus_stop();
    check("R6 restart discards partial", {8'h0, ctrl_word}, {8'h0, mword()});
    check("R11 released after stop", {31'h0, sda_oe}, 32'h0);

    // R1: reset again restores all-on
    rst = 1'b1;
    pause(3);
    rst = 1'b0;
    pause(2);
    check("R1 re-reset word", {8'h0, ctrl_word}, 32'h00FFFFFF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule